// File: doc/BRIEF.md
# Software and RMA Host Arbiter

This block decides who may drive a flash protocol controller: a software command port that issues read, program and erase jobs, or a hardware port that requests a return-material wipe. Software commands are screened before they are granted. Erase kind, target partition and the lifecycle enables for the protected info pages all take part. A command that passes gets a single-cycle start towards the controller and stays outstanding until the controller's done pulse.

When a wipe request is seen, the block lets any outstanding software job finish first. It then drives a wipe request downstream until the wipe reports done. After that it answers the hardware host, echoing the seed taken with the request. Once the wipe path is taken, the controller belongs to it until reset. The state machine stays in its response state. Later software commands are dropped without a start, an error or a done, so software sees only a timeout.

The state machine walks IDLE to DRAIN (request while a job is outstanding), or IDLE straight to WIPE (nothing outstanding). It goes DRAIN to WIPE on the controller's done pulse, and WIPE to RESP on the wipe done. RESP is terminal, and any unrecognised code also lands in RESP. The codes are IDLE 11'b01101001100, DRAIN 11'b11010010110, WIPE 11'b00011111010 and RESP 11'b10100100001.

Top module: `swrma_arbiter`

## Requirements
- R1: A wipe request that arrives while a software job is outstanding leaves `wipe_req_o` low until the controller's done for that job, which is still forwarded as `sw_done_o`. `wipe_req_o` rises in the cycle after that done.
- R2: Once in RESP, `rma_state_o` holds 11'b10100100001 and `rma_ack_o` stays high until reset, whatever the inputs do.
- R3: From the cycle a wipe request is taken, software requests produce no `ctl_start_o`, no `sw_err_o` and no `sw_done_o`.
- R4: `rma_ack_o` rises only in the cycle after `wipe_done_i`. `rma_seed_o` then shows the `rma_seed_i` value sampled with the accepted request.
- R5: If a software request and a wipe request arrive in the same cycle with nothing outstanding, the wipe wins. The software request is never started and raises no error, and `wipe_req_o` is high in the next cycle.
- R6: A legal software request, made in IDLE with nothing outstanding, gives a one-cycle `ctl_start_o` in the next cycle with the command fields copied to the `ctl_*` outputs. The controller's done for that job appears on `sw_done_o` in the same cycle.
- R7: Op codes are 0 read, 1 program, 2 erase, and 3 is illegal. Partition codes are 0 data, 1 info0, 2 info1, 3 info2, 4 redundancy, and 5 to 7 are illegal. A bank erase (`sw_bank_erase_i`=1 with op 2) is legal only on partitions 0 and 1. An illegal request gives a one-cycle `sw_err_o` in the next cycle and no start.
- R8: Partition 4 accepts only op 0.
- R9: On partition 1 only, `sw_page_i` selects the gate. Value 1 needs `lc_creator_en_i`. Value 2 needs `lc_owner_en_i`. Value 3 needs `lc_iso_rd_en_i` for reads and `lc_iso_wr_en_i` for program or erase. Value 0 is ungated.
- R10: A software request made while a job is outstanding is dropped, with no start and no error.
- R11: After reset `rma_state_o` is 11'b01101001100 (IDLE), and `rma_ack_o`, `wipe_req_o` and `ctl_start_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req_i | input | 1 | Software command request, sampled each cycle |
| sw_op_i | input | 2 | Operation code |
| sw_bank_erase_i | input | 1 | Erase whole bank instead of one page |
| sw_part_i | input | 3 | Partition code |
| sw_page_i | input | 2 | Protected info page class |
| sw_addr_i | input | ADDR_W | Start address |
| sw_words_i | input | WORDS_W | Word count |
| lc_creator_en_i | input | 1 | Creator page enable |
| lc_owner_en_i | input | 1 | Owner page enable |
| lc_iso_rd_en_i | input | 1 | Isolated page read enable |
| lc_iso_wr_en_i | input | 1 | Isolated page write enable |
| sw_err_o | output | 1 | Illegal command pulse |
| sw_done_o | output | 1 | Software job done pulse |
| ctl_start_o | output | 1 | Start pulse to controller |
| ctl_op_o | output | 2 | Granted op |
| ctl_bank_erase_o | output | 1 | Granted erase kind |
| ctl_part_o | output | 3 | Granted partition |
| ctl_addr_o | output | ADDR_W | Granted address |
| ctl_words_o | output | WORDS_W | Granted word count |
| ctl_done_i | input | 1 | Controller job done pulse |
| rma_req_i | input | 1 | Hardware wipe request |
| rma_seed_i | input | SEED_W | Seed sent with the request |
| rma_ack_o | output | 1 | Wipe response, held in RESP |
| rma_seed_o | output | SEED_W | Echoed seed |
| wipe_req_o | output | 1 | Downstream wipe request |
| wipe_done_i | input | 1 | Downstream wipe done |
| rma_state_o | output | 11 | Current state code |

## Verification
The bench builds the block with ADDR_W=12, WORDS_W=4 and SEED_W=16. These narrow widths make the field copies and the seed echo quick to compare, and they leave every legality rule and every state transition fully in reach. A table of commands covers each mix of partition, op, erase kind, page class and lifecycle enable that decides legality. Directed sequences then drive the drain path, the same-cycle race, the terminal hold with later stimulus, and reset.

// File: rtl/swrma_pkg.sv
package swrma_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BAD   = 2'd3
    } sw_op_e;

    typedef enum logic [2:0] {
        PART_DATA  = 3'd0,
        PART_INFO0 = 3'd1,
        PART_INFO1 = 3'd2,
        PART_INFO2 = 3'd3,
        PART_RED   = 3'd4
    } part_e;

    typedef enum logic [1:0] {
        PG_PLAIN   = 2'd0,
        PG_CREATOR = 2'd1,
        PG_OWNER   = 2'd2,
        PG_ISO     = 2'd3
    } page_e;

    localparam int STATE_W = 11;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 11'b01101001100,
        ST_DRAIN = 11'b11010010110,
        ST_WIPE  = 11'b00011111010,
        ST_RESP  = 11'b10100100001
    } rma_state_e;

endpackage

// File: rtl/swrma_cmd_check.sv
module swrma_cmd_check
    import swrma_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic       bank_erase_i,
    input  logic [2:0] part_i,
    input  logic [1:0] page_i,
    input  logic       lc_creator_en_i,
    input  logic       lc_owner_en_i,
    input  logic       lc_iso_rd_en_i,
    input  logic       lc_iso_wr_en_i,
    output logic       legal_o
);

    logic op_ok, part_ok, erase_ok, red_ok, gate_ok, is_read;

    always_comb begin
        is_read  = (op_i == OP_READ);
        op_ok    = (op_i != OP_BAD);
        part_ok  = (part_i <= PART_RED);
        erase_ok = !((op_i == OP_ERASE) && bank_erase_i &&
                     (part_i != PART_DATA) && (part_i != PART_INFO0));
        red_ok   = (part_i != PART_RED) || is_read;
        gate_ok  = 1'b1;
        if (part_i == PART_INFO0) begin
            unique case (page_i)
                PG_CREATOR: gate_ok = lc_creator_en_i;
                PG_OWNER:   gate_ok = lc_owner_en_i;
                PG_ISO:     gate_ok = is_read ? lc_iso_rd_en_i : lc_iso_wr_en_i;
                default:    gate_ok = 1'b1;
            endcase
        end
        legal_o = op_ok && part_ok && erase_ok && red_ok && gate_ok;
    end

endmodule

// File: rtl/swrma_sw_port.sv
module swrma_sw_port #(
    parameter int ADDR_W  = 20,
    parameter int WORDS_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_req_i,
    input  logic [1:0]         sw_op_i,
    input  logic               sw_bank_erase_i,
    input  logic [2:0]         sw_part_i,
    input  logic [ADDR_W-1:0]  sw_addr_i,
    input  logic [WORDS_W-1:0] sw_words_i,
    input  logic               legal_i,
    input  logic               open_i,
    input  logic               rma_req_i,
    input  logic               ctl_done_i,
    output logic               ctl_start_o,
    output logic [1:0]         ctl_op_o,
    output logic               ctl_bank_erase_o,
    output logic [2:0]         ctl_part_o,
    output logic [ADDR_W-1:0]  ctl_addr_o,
    output logic [WORDS_W-1:0] ctl_words_o,
    output logic               sw_err_o,
    output logic               sw_done_o,
    output logic               busy_o
);

    logic grant, busy_q, start_q, err_q;

    // A request is considered only when the arbiter is open, nothing is
    // outstanding and no wipe request competes in the same cycle.
    assign grant = open_i && sw_req_i && !busy_q && !rma_req_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            start_q <= grant && legal_i;
            err_q   <= grant && !legal_i;
            if (grant && legal_i) begin
                busy_q <= 1'b1;
            end else if (ctl_done_i) begin
                busy_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_op_o         <= '0;
            ctl_bank_erase_o <= 1'b0;
            ctl_part_o       <= '0;
            ctl_addr_o       <= '0;
            ctl_words_o      <= '0;
        end else if (grant && legal_i) begin
            ctl_op_o         <= sw_op_i;
            ctl_bank_erase_o <= sw_bank_erase_i;
            ctl_part_o       <= sw_part_i;
            ctl_addr_o       <= sw_addr_i;
            ctl_words_o      <= sw_words_i;
        end
    end

    assign ctl_start_o = start_q;
    assign sw_err_o    = err_q;
    assign sw_done_o   = ctl_done_i && busy_q;
    assign busy_o      = busy_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_start_o |=> !ctl_start_o); // R6
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !ctl_done_i) |=> !ctl_start_o); // R10

endmodule

// File: rtl/swrma_rma_fsm.sv
module swrma_rma_fsm
    import swrma_pkg::*;
#(
    parameter int SEED_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rma_req_i,
    input  logic [SEED_W-1:0] rma_seed_i,
    input  logic              busy_i,
    input  logic              ctl_done_i,
    input  logic              wipe_done_i,
    output logic              open_o,
    output logic              wipe_req_o,
    output logic              rma_ack_o,
    output logic [SEED_W-1:0] rma_seed_o,
    output logic [STATE_W-1:0] state_o
);

    rma_state_e state_q, state_d;
    logic [SEED_W-1:0] seed_q;
    logic take_req;

    assign take_req = (state_q == ST_IDLE) && rma_req_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rma_req_i) begin
                    state_d = (busy_i && !ctl_done_i) ? ST_DRAIN : ST_WIPE;
                end
            end
            ST_DRAIN: begin
                if (ctl_done_i) state_d = ST_WIPE;
            end
            ST_WIPE: begin
                if (wipe_done_i) state_d = ST_RESP;
            end
            ST_RESP:  state_d = ST_RESP;
            default:  state_d = ST_RESP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
        end else if (take_req) begin
            seed_q <= rma_seed_i;
        end
    end

    always_comb begin
        open_o     = 1'b0;
        wipe_req_o = 1'b0;
        rma_ack_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  open_o     = 1'b1;
            ST_DRAIN: open_o     = 1'b0;
            ST_WIPE:  wipe_req_o = 1'b1;
            ST_RESP:  rma_ack_o  = 1'b1;
            default:  rma_ack_o  = 1'b1;
        endcase
    end

    assign rma_seed_o = seed_q;
    assign state_o    = state_q;

    AST_TERMINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESP) |=> (state_q == ST_RESP) && $stable(rma_seed_o)); // R2
    AST_NO_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE)); // R3
    AST_ACK_AFTER_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rma_ack_o) |-> $past(wipe_done_i)); // R4

endmodule

// File: rtl/swrma_arbiter.sv
module swrma_arbiter
    import swrma_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int WORDS_W = 5,
    parameter int SEED_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_req_i,
    input  logic [1:0]         sw_op_i,
    input  logic               sw_bank_erase_i,
    input  logic [2:0]         sw_part_i,
    input  logic [1:0]         sw_page_i,
    input  logic [ADDR_W-1:0]  sw_addr_i,
    input  logic [WORDS_W-1:0] sw_words_i,
    input  logic               lc_creator_en_i,
    input  logic               lc_owner_en_i,
    input  logic               lc_iso_rd_en_i,
    input  logic               lc_iso_wr_en_i,
    output logic               sw_err_o,
    output logic               sw_done_o,
    output logic               ctl_start_o,
    output logic [1:0]         ctl_op_o,
    output logic               ctl_bank_erase_o,
    output logic [2:0]         ctl_part_o,
    output logic [ADDR_W-1:0]  ctl_addr_o,
    output logic [WORDS_W-1:0] ctl_words_o,
    input  logic               ctl_done_i,
    input  logic               rma_req_i,
    input  logic [SEED_W-1:0]  rma_seed_i,
    output logic               rma_ack_o,
    output logic [SEED_W-1:0]  rma_seed_o,
    output logic               wipe_req_o,
    input  logic               wipe_done_i,
    output logic [10:0]        rma_state_o
);

    logic legal, open, sw_busy;

    swrma_cmd_check u_check (
        .op_i            (sw_op_i),
        .bank_erase_i    (sw_bank_erase_i),
        .part_i          (sw_part_i),
        .page_i          (sw_page_i),
        .lc_creator_en_i (lc_creator_en_i),
        .lc_owner_en_i   (lc_owner_en_i),
        .lc_iso_rd_en_i  (lc_iso_rd_en_i),
        .lc_iso_wr_en_i  (lc_iso_wr_en_i),
        .legal_o         (legal)
    );

    swrma_sw_port #(.ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) u_sw (
        .clk              (clk),
        .rst_n            (rst_n),
        .sw_req_i         (sw_req_i),
        .sw_op_i          (sw_op_i),
        .sw_bank_erase_i  (sw_bank_erase_i),
        .sw_part_i        (sw_part_i),
        .sw_addr_i        (sw_addr_i),
        .sw_words_i       (sw_words_i),
        .legal_i          (legal),
        .open_i           (open),
        .rma_req_i        (rma_req_i),
        .ctl_done_i       (ctl_done_i),
        .ctl_start_o      (ctl_start_o),
        .ctl_op_o         (ctl_op_o),
        .ctl_bank_erase_o (ctl_bank_erase_o),
        .ctl_part_o       (ctl_part_o),
        .ctl_addr_o       (ctl_addr_o),
        .ctl_words_o      (ctl_words_o),
        .sw_err_o         (sw_err_o),
        .sw_done_o        (sw_done_o),
        .busy_o           (sw_busy)
    );

    swrma_rma_fsm #(.SEED_W(SEED_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rma_req_i   (rma_req_i),
        .rma_seed_i  (rma_seed_i),
        .busy_i      (sw_busy),
        .ctl_done_i  (ctl_done_i),
        .wipe_done_i (wipe_done_i),
        .open_o      (open),
        .wipe_req_o  (wipe_req_o),
        .rma_ack_o   (rma_ack_o),
        .rma_seed_o  (rma_seed_o),
        .state_o     (rma_state_o)
    );

    AST_WIPE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_req_o |-> !sw_busy); // R1
    AST_RMA_BEATS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (rma_req_i && open && !sw_busy) |=> !ctl_start_o); // R5
    AST_ERR_EXCLUDES_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_start_o && sw_err_o)); // R7

endmodule

// File: tb/swrma_arbiter_tb_top.sv
module swrma_arbiter_tb_top;

    localparam int AW = 12;
    localparam int WW = 4;
    localparam int SW = 16;
    localparam logic [10:0] C_IDLE = 11'b01101001100;
    localparam logic [10:0] C_RESP = 11'b10100100001;

    // {part[3], op[2], bank[1], page[2], lc{creator,owner,iso_rd,iso_wr}[4], exp_err[1]}
    localparam int NV = 19;
    localparam logic [12:0] VEC [NV] = '{
        {3'd0, 2'd0, 1'b0, 2'd0, 4'b0000, 1'b0},
        {3'd0, 2'd1, 1'b0, 2'd0, 4'b0000, 1'b0},
        {3'd0, 2'd2, 1'b1, 2'd0, 4'b0000, 1'b0},
        {3'd1, 2'd2, 1'b1, 2'd0, 4'b0000, 1'b0},
        {3'd2, 2'd2, 1'b1, 2'd0, 4'b0000, 1'b1},
        {3'd3, 2'd2, 1'b1, 2'd0, 4'b0000, 1'b1},
        {3'd2, 2'd2, 1'b0, 2'd0, 4'b0000, 1'b0},
        {3'd4, 2'd0, 1'b0, 2'd0, 4'b0000, 1'b0},
        {3'd4, 2'd1, 1'b0, 2'd0, 4'b0000, 1'b1},
        {3'd4, 2'd2, 1'b0, 2'd0, 4'b0000, 1'b1},
        {3'd1, 2'd1, 1'b0, 2'd1, 4'b0111, 1'b1},
        {3'd1, 2'd1, 1'b0, 2'd1, 4'b1000, 1'b0},
        {3'd1, 2'd0, 1'b0, 2'd2, 4'b1011, 1'b1},
        {3'd1, 2'd0, 1'b0, 2'd3, 4'b0010, 1'b0},
        {3'd1, 2'd1, 1'b0, 2'd3, 4'b0010, 1'b1},
        {3'd1, 2'd2, 1'b0, 2'd3, 4'b0001, 1'b0},
        {3'd0, 2'd3, 1'b0, 2'd0, 4'b1111, 1'b1},
        {3'd6, 2'd0, 1'b0, 2'd0, 4'b1111, 1'b1},
        {3'd2, 2'd1, 1'b0, 2'd3, 4'b0000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_req = 1'b0, sw_bank = 1'b0;
    logic [1:0] sw_op = '0, sw_page = '0;
    logic [2:0] sw_part = '0;
    logic [AW-1:0] sw_addr = '0;
    logic [WW-1:0] sw_words = '0;
    logic lc_cr = 1'b0, lc_ow = 1'b0, lc_ir = 1'b0, lc_iw = 1'b0;
    logic ctl_done = 1'b0, rma_req = 1'b0, wipe_done = 1'b0;
    logic [SW-1:0] rma_seed = '0;
    logic sw_err, sw_done, ctl_start, ctl_bank, rma_ack, wipe_req;
    logic [1:0] ctl_op;
    logic [2:0] ctl_part;
    logic [AW-1:0] ctl_addr;
    logic [WW-1:0] ctl_words;
    logic [SW-1:0] rma_seed_o;
    logic [10:0] st;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    swrma_arbiter #(.ADDR_W(AW), .WORDS_W(WW), .SEED_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sw_req_i(sw_req), .sw_op_i(sw_op), .sw_bank_erase_i(sw_bank),
        .sw_part_i(sw_part), .sw_page_i(sw_page), .sw_addr_i(sw_addr),
        .sw_words_i(sw_words),
        .lc_creator_en_i(lc_cr), .lc_owner_en_i(lc_ow),
        .lc_iso_rd_en_i(lc_ir), .lc_iso_wr_en_i(lc_iw),
        .sw_err_o(sw_err), .sw_done_o(sw_done), .ctl_start_o(ctl_start),
        .ctl_op_o(ctl_op), .ctl_bank_erase_o(ctl_bank), .ctl_part_o(ctl_part),
        .ctl_addr_o(ctl_addr), .ctl_words_o(ctl_words), .ctl_done_i(ctl_done),
        .rma_req_i(rma_req), .rma_seed_i(rma_seed), .rma_ack_o(rma_ack),
        .rma_seed_o(rma_seed_o), .wipe_req_o(wipe_req), .wipe_done_i(wipe_done),
        .rma_state_o(st)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Holds the request for one edge; returns at the following negedge.
    task automatic issue(input logic [2:0] p, input logic [1:0] o, input logic b,
                         input logic [1:0] g, input logic [AW-1:0] a);
        sw_part = p; sw_op = o; sw_bank = b; sw_page = g; sw_addr = a;
        sw_words = a[WW-1:0];
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
    endtask

    task automatic pulse_done(input string tag, input logic exp_done);
        ctl_done = 1'b1;
        #1;
        chk(tag, sw_done, exp_done);
        @(negedge clk);
        ctl_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R11 state", st, C_IDLE);
        chk("R11 ack", rma_ack, 0);
        chk("R11 wipe", wipe_req, 0);
        chk("R11 start", ctl_start, 0);

        // Legality table (R6, R7, R8, R9)
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            {lc_cr, lc_ow, lc_ir, lc_iw} = v[4:1];
            issue(v[12:10], v[9:8], v[7], v[6:5], AW'(37 * i + 5));
            chk($sformatf("R7 err vec%0d", i), sw_err, v[0]);
            chk($sformatf("R6 start vec%0d", i), ctl_start, !v[0]);
            if (!v[0]) begin
                chk($sformatf("R6 part vec%0d", i), ctl_part, v[12:10]);
                chk($sformatf("R6 addr vec%0d", i), ctl_addr, AW'(37 * i + 5));
                pulse_done($sformatf("R6 done vec%0d", i), 1'b1);
            end
        end
        lc_cr = 1'b0; lc_ow = 1'b0; lc_ir = 1'b0; lc_iw = 1'b0;

        // R10: second request while outstanding is dropped
        issue(3'd0, 2'd0, 1'b0, 2'd0, 12'h111);
        chk("R10 first start", ctl_start, 1);
        issue(3'd0, 2'd1, 1'b0, 2'd0, 12'h222);
        chk("R10 no start", ctl_start, 0);
        chk("R10 no err", sw_err, 0);
        issue(3'd7, 2'd3, 1'b0, 2'd0, 12'h333);
        chk("R10 illegal no err", sw_err, 0);
        pulse_done("R10 done", 1'b1);

        // R1: drain an outstanding job before the wipe
        issue(3'd0, 2'd2, 1'b0, 2'd0, 12'h0A0);
        chk("R1 start", ctl_start, 1);
        rma_seed = 16'hBEEF;
        rma_req = 1'b1;
        @(negedge clk);
        rma_req = 1'b0;
        rma_seed = 16'h0000;
        chk("R1 wipe held", wipe_req, 0);
        repeat (3) @(negedge clk);
        chk("R1 wipe still held", wipe_req, 0);
        pulse_done("R1 drained done", 1'b1);
        chk("R1 wipe rises", wipe_req, 1);

        // R3: software ignored once wipe path taken
        issue(3'd0, 2'd0, 1'b0, 2'd0, 12'h0B0);
        chk("R3 no start", ctl_start, 0);
        chk("R3 no err", sw_err, 0);
        issue(3'd6, 2'd0, 1'b0, 2'd0, 12'h0B1);
        chk("R3 illegal no err", sw_err, 0);
        pulse_done("R3 no done", 1'b0);

        // R4: response after wipe done with captured seed
        chk("R4 ack before wipe done", rma_ack, 0);
        wipe_done = 1'b1;
        @(negedge clk);
        wipe_done = 1'b0;
        chk("R4 ack", rma_ack, 1);
        chk("R4 seed", rma_seed_o, 16'hBEEF);
        chk("R2 state", st, C_RESP);

        // R2: terminal hold under further stimulus
        repeat (20) @(negedge clk);
        rma_seed = 16'h1234;
        rma_req = 1'b1;
        wipe_done = 1'b1;
        issue(3'd0, 2'd0, 1'b0, 2'd0, 12'h0C0);
        rma_req = 1'b0;
        wipe_done = 1'b0;
        chk("R3 late no start", ctl_start, 0);
        chk("R2 state hold", st, C_RESP);
        chk("R2 ack hold", rma_ack, 1);
        chk("R4 seed hold", rma_seed_o, 16'hBEEF);

        // R5: same-cycle race, wipe wins
        do_reset();
        chk("R11 state again", st, C_IDLE);
        rma_seed = 16'h5A5A;
        rma_req = 1'b1;
        issue(3'd0, 2'd0, 1'b0, 2'd0, 12'h0D0);
        rma_req = 1'b0;
        chk("R5 no start", ctl_start, 0);
        chk("R5 no err", sw_err, 0);
        chk("R5 wipe", wipe_req, 1);
        wipe_done = 1'b1;
        @(negedge clk);
        wipe_done = 1'b0;
        chk("R5 seed", rma_seed_o, 16'h5A5A);
        chk("R5 ack", rma_ack, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule